// File: doc/BRIEF.md
# Keyboard Controller Output Port with A20 Gate and Reset Pulse

This block holds the 8-bit output port of a keyboard controller. The port drives the A20 address gate and can raise a request to reset the processor. A command engine upstream changes the port in two ways. It can write the whole byte through a data strobe. It can also pass on single command codes: one code turns the A20 gate on, one turns it off, and a family of codes pulses chosen low port bits low for a fixed time.

The read-back value always carries the two output-buffer-full flags in their mirror bits, so the command engine can return the port in answer to a read-port command. All outputs are registered and a synchronous active-high reset loads the power-on value. The pulse width is a clock-cycle count parameter. A pulse code that arrives while a pulse is still running is dropped. The reset request is a single-cycle strobe.

Top module: `kbc_outport`

## Requirements
- R1: After reset, `port_val` reads 0xCF, `a20_gate` is 1 and `cpu_reset_req` is 0.
- R2: A cycle with `wr_en` high stores `wr_data`. From the next cycle, `port_val` bits 7:6 and 3:0 show the written bits, and `a20_gate` equals written bit 1, unless a pulse is masking those bits.
- R3: A port write whose bit 0 is 0 makes `cpu_reset_req` high for exactly the following cycle. A write with bit 0 equal to 1 raises no request.
- R4: Command code 0xDF sets stored bit 1 and raises `a20_gate` in the next cycle. Code 0xDD clears bit 1 and lowers `a20_gate`. No other port bit changes.
- R5: A command code whose upper nibble is 0xF starts a pulse. Every 0 bit in the low nibble selects the port bit of the same position. The selected bits read 0 on `port_val` (and bit 1 also on `a20_gate`) for exactly PULSE_CYCLES cycles, starting the cycle after the command. After that they show the stored value again.
- R6: A pulse that selects bit 0 makes `cpu_reset_req` high for exactly the cycle after the command. Code 0xFF selects nothing: it starts no pulse and raises no request.
- R7: A pulse code that arrives while a pulse is active is ignored. It masks no more bits and raises no request.
- R8: `port_val` bit 4 shows `kbd_full` and bit 5 shows `aux_full`, each one cycle later. Written values for bits 4 and 5 are ignored.
- R9: A write and a command in the same cycle both take effect. An A20 command overrides the written bit 1. A write with bit 0 low together with a bit-0 pulse gives a single one-cycle reset request.
- R10: Command codes other than 0xDD, 0xDF and 0xF0–0xFF leave `port_val`, `a20_gate` and `cpu_reset_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Full port write strobe |
| wr_data | input | 8 | Port value to write |
| cmd_en | input | 1 | Command code strobe |
| cmd_code | input | 8 | Command code (A20 on/off, pulse family, others ignored) |
| kbd_full | input | 1 | Keyboard output buffer full flag |
| aux_full | input | 1 | Auxiliary output buffer full flag |
| port_val | output | 8 | Current port value for read-back |
| a20_gate | output | 1 | A20 gate output |
| cpu_reset_req | output | 1 | One-cycle processor reset request |

## Verification
A full port write and a command code can arrive in the same cycle, and they must merge rather than one hiding the other. The bench drives a write of 0x01 together with 0xDF and expects 0x03 with the gate high. It then drives a write of 0xCE together with the bit-0 pulse 0xFE and expects the masked value during the pulse, the stored 0xCE after it, and a reset request exactly one cycle wide. A second pulse issued in the middle of a running pulse is judged by checking that bit 1 stays high and no request appears.

// File: rtl/kbc_outport_pkg.sv
package kbc_outport_pkg;
  localparam int          PORT_W       = 8;
  localparam int          NIB_W        = 4;
  localparam logic [7:0]  PORT_INIT    = 8'hCF;
  localparam logic [7:0]  STORE_KEEP   = 8'hCF;   // bits 5:4 are mirrors, not stored
  localparam logic [7:0]  CODE_A20_ON  = 8'hDF;
  localparam logic [7:0]  CODE_A20_OFF = 8'hDD;
  localparam logic [3:0]  PULSE_GROUP  = 4'hF;
  localparam int          BIT_RESET    = 0;
  localparam int          BIT_A20      = 1;
  localparam int          BIT_KBD_FULL = 4;
  localparam int          BIT_AUX_FULL = 5;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_outport_pkg::*;
(
  input  logic             cmd_en,
  input  logic [7:0]       cmd_code,
  output logic             a20_set,
  output logic             a20_clr,
  output logic             pulse_req,
  output logic [NIB_W-1:0] pulse_sel
);
  always_comb begin
    a20_set   = cmd_en && (cmd_code == CODE_A20_ON);
    a20_clr   = cmd_en && (cmd_code == CODE_A20_OFF);
    pulse_req = cmd_en && (cmd_code[7:4] == PULSE_GROUP);
    // a zero bit in the low nibble selects that port bit
    pulse_sel = ~cmd_code[NIB_W-1:0];
  end
endmodule

// File: rtl/kbc_pulse_timer.sv
module kbc_pulse_timer
  import kbc_outport_pkg::*;
#(
  parameter int PULSE_CYCLES = 750
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [NIB_W-1:0] sel,
  output logic             start,
  output logic             active,
  output logic [NIB_W-1:0] mask_nxt
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NIB_W-1:0] mask_q;

  assign start  = req && !active_q && (sel != '0);
  assign active = active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    mask_nxt = mask_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = CNT_W'(PULSE_CYCLES - 1);
      mask_nxt = sel;
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_d = 1'b0;
        mask_nxt = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      mask_q   <= mask_nxt;
    end
  end
endmodule

// File: rtl/kbc_port_store.sv
module kbc_port_store
  import kbc_outport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              a20_set,
  input  logic              a20_clr,
  output logic [PORT_W-1:0] store_nxt
);
  logic [PORT_W-1:0] store_q;

  always_comb begin
    store_nxt = store_q;
    if (wr_en)   store_nxt = wr_data & STORE_KEEP;
    if (a20_set) store_nxt[BIT_A20] = 1'b1;
    if (a20_clr) store_nxt[BIT_A20] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) store_q <= PORT_INIT & STORE_KEEP;
    else     store_q <= store_nxt;
  end
endmodule

// File: rtl/kbc_outport.sv
module kbc_outport
  import kbc_outport_pkg::*;
#(
  parameter int PULSE_CYCLES = 750
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_en,
  input  logic [7:0] cmd_code,
  input  logic       kbd_full,
  input  logic       aux_full,
  output logic [7:0] port_val,
  output logic       a20_gate,
  output logic       cpu_reset_req
);
  logic             a20_set, a20_clr, pulse_req, pulse_start, pulse_active;
  logic [NIB_W-1:0] pulse_sel, mask_nxt;
  logic [7:0]       store_nxt, port_nxt, flag_bits;

  kbc_cmd_decode u_dec (
    .cmd_en    (cmd_en),
    .cmd_code  (cmd_code),
    .a20_set   (a20_set),
    .a20_clr   (a20_clr),
    .pulse_req (pulse_req),
    .pulse_sel (pulse_sel)
  );

  kbc_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .req      (pulse_req),
    .sel      (pulse_sel),
    .start    (pulse_start),
    .active   (pulse_active),
    .mask_nxt (mask_nxt)
  );

  kbc_port_store u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .a20_set   (a20_set),
    .a20_clr   (a20_clr),
    .store_nxt (store_nxt)
  );

  always_comb begin
    flag_bits               = '0;
    flag_bits[BIT_KBD_FULL] = kbd_full;
    flag_bits[BIT_AUX_FULL] = aux_full;
    port_nxt = (store_nxt & ~{{(PORT_W-NIB_W){1'b0}}, mask_nxt}) | flag_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_val      <= PORT_INIT;
      a20_gate      <= PORT_INIT[BIT_A20];
      cpu_reset_req <= 1'b0;
    end else begin
      port_val      <= port_nxt;
      a20_gate      <= port_nxt[BIT_A20];
      cpu_reset_req <= (wr_en && !wr_data[BIT_RESET]) ||
                       (pulse_start && pulse_sel[BIT_RESET]);
    end
  end
endmodule

// File: rtl/kbc_outport_chk.sv
module kbc_outport_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       cmd_en,
  input logic [7:0] cmd_code,
  input logic       kbd_full,
  input logic       aux_full,
  input logic [7:0] port_val,
  input logic       a20_gate,
  input logic       cpu_reset_req,
  input logic       pulse_active
);
  logic special;
  assign special = (cmd_code == 8'hDD) || (cmd_code == 8'hDF) || (cmd_code[7:4] == 4'hF);

  // R3: a write with bit 0 low requests a reset next cycle
  a_r3_write_reset: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_data[0] |=> cpu_reset_req);

  // R2: written upper bits appear on the port
  a_r2_write_high: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> port_val[7:6] == $past(wr_data[7:6]));

  // R4: A20 on/off when no pulse masks the bit
  a_r4_a20_on: assert property (@(posedge clk) disable iff (rst)
    cmd_en && cmd_code == 8'hDF && !pulse_active |=> a20_gate && port_val[1]);
  a_r4_a20_off: assert property (@(posedge clk) disable iff (rst)
    cmd_en && cmd_code == 8'hDD |=> !a20_gate && !port_val[1]);

  // R8: mirrored buffer-full flags
  a_r8_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> port_val[4] == $past(kbd_full) && port_val[5] == $past(aux_full));

  // R6: code 0xFF alone raises no request
  a_r6_ff_quiet: assert property (@(posedge clk) disable iff (rst)
    cmd_en && cmd_code == 8'hFF && !wr_en |=> !cpu_reset_req);

  // R10: other codes leave the low port bits alone
  a_r10_ignored: assert property (@(posedge clk) disable iff (rst)
    cmd_en && !special && !wr_en && !pulse_active |=> $stable(port_val[3:0]));
endmodule

bind kbc_outport kbc_outport_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .cmd_en        (cmd_en),
  .cmd_code      (cmd_code),
  .kbd_full      (kbd_full),
  .aux_full      (aux_full),
  .port_val      (port_val),
  .a20_gate      (a20_gate),
  .cpu_reset_req (cpu_reset_req),
  .pulse_active  (pulse_active)
);

// File: tb/test_kbc_outport.sv
`timescale 1ns/1ps
module test_kbc_outport;
  localparam int PW = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_en = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       kbd_full = 1'b0;
  logic       aux_full = 1'b0;
  logic [7:0] port_val;
  logic       a20_gate;
  logic       cpu_reset_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  kbc_outport #(.PULSE_CYCLES(PW)) i_kbc_outport (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_en(cmd_en), .cmd_code(cmd_code), .kbd_full(kbd_full),
    .aux_full(aux_full), .port_val(port_val), .a20_gate(a20_gate),
    .cpu_reset_req(cpu_reset_req)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus, then sample after the capturing edge
  task automatic step(logic we, logic [7:0] wd, logic ce, logic [7:0] cc);
    @(negedge clk);
    wr_en = we; wr_data = wd; cmd_en = ce; cmd_code = cc;
    @(negedge clk);
    wr_en = 1'b0; cmd_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 port", port_val, 8'hCF);
    check("R1 a20", {7'd0, a20_gate}, 8'd1);
    check("R1 req", {7'd0, cpu_reset_req}, 8'd0);
  endtask

  task automatic t_write();
    step(1'b1, 8'h41, 1'b0, 8'h00);
    check("R2 port", port_val, 8'h41);
    check("R2 a20", {7'd0, a20_gate}, 8'd0);
    check("R3 no req", {7'd0, cpu_reset_req}, 8'd0);
    step(1'b1, 8'h82, 1'b0, 8'h00);
    check("R2 port b", port_val, 8'h82);
    check("R2 a20 b", {7'd0, a20_gate}, 8'd1);
    check("R3 req", {7'd0, cpu_reset_req}, 8'd1);
    idle(1);
    check("R3 one cycle", {7'd0, cpu_reset_req}, 8'd0);
    step(1'b1, 8'hCF, 1'b0, 8'h00);
    check("R2 restore", port_val, 8'hCF);
  endtask

  task automatic t_a20();
    step(1'b0, 8'h00, 1'b1, 8'hDD);
    check("R4 off port", port_val, 8'hCD);
    check("R4 off a20", {7'd0, a20_gate}, 8'd0);
    step(1'b0, 8'h00, 1'b1, 8'hDF);
    check("R4 on port", port_val, 8'hCF);
    check("R4 on a20", {7'd0, a20_gate}, 8'd1);
  endtask

  task automatic t_pulse();
    int lows = 0;
    step(1'b0, 8'h00, 1'b1, 8'hF5);   // bits 1 and 3
    check("R5 first", port_val, 8'hC5);
    check("R5 a20 low", {7'd0, a20_gate}, 8'd0);
    check("R6 no req bit0 kept", {7'd0, cpu_reset_req}, 8'd0);
    lows = 1;
    for (int i = 0; i < PW + 3; i++) begin
      @(negedge clk);
      if (port_val == 8'hC5) lows++;
    end
    check("R5 width", lows[7:0], PW[7:0]);
    check("R5 restored", port_val, 8'hCF);
    step(1'b0, 8'h00, 1'b1, 8'hF0);
    check("R5 all four", port_val, 8'hC0);
    check("R6 req", {7'd0, cpu_reset_req}, 8'd1);
    idle(1);
    check("R6 one cycle", {7'd0, cpu_reset_req}, 8'd0);
    idle(PW);
    check("R5 end", port_val, 8'hCF);
    step(1'b0, 8'h00, 1'b1, 8'hFF);
    check("R6 ff port", port_val, 8'hCF);
    check("R6 ff req", {7'd0, cpu_reset_req}, 8'd0);
  endtask

  task automatic t_busy();
    step(1'b0, 8'h00, 1'b1, 8'hFE);
    check("R7 start", port_val, 8'hCE);
    idle(3);
    step(1'b0, 8'h00, 1'b1, 8'hFD);
    check("R7 second dropped", port_val, 8'hCE);
    check("R7 a20 kept", {7'd0, a20_gate}, 8'd1);
    check("R7 no req", {7'd0, cpu_reset_req}, 8'd0);
    idle(PW);
    check("R7 end", port_val, 8'hCF);
  endtask

  task automatic t_mirror();
    @(negedge clk); kbd_full = 1'b1;
    @(negedge clk);
    check("R8 kbd", port_val, 8'hDF);
    aux_full = 1'b1; kbd_full = 1'b0;
    @(negedge clk);
    check("R8 aux", port_val, 8'hEF);
    aux_full = 1'b0;
    step(1'b1, 8'hFF, 1'b0, 8'h00);
    check("R8 written ignored", port_val, 8'hCF);
  endtask

  task automatic t_same_cycle();
    step(1'b1, 8'h01, 1'b1, 8'hDF);
    check("R9 write+a20", port_val, 8'h03);
    check("R9 a20", {7'd0, a20_gate}, 8'd1);
    step(1'b1, 8'hCE, 1'b1, 8'hFE);
    check("R9 write+pulse port", port_val, 8'hCE);
    check("R9 req", {7'd0, cpu_reset_req}, 8'd1);
    idle(1);
    check("R9 single req", {7'd0, cpu_reset_req}, 8'd0);
    idle(PW + 1);
    check("R9 stored", port_val, 8'hCE);
    step(1'b1, 8'hCF, 1'b0, 8'h00);
    check("R9 restore", port_val, 8'hCF);
  endtask

  task automatic t_ignored();
    logic [7:0] codes [3] = '{8'h20, 8'hD1, 8'hE0};
    foreach (codes[i]) begin
      step(1'b0, 8'h00, 1'b1, codes[i]);
      check("R10 port", port_val, 8'hCF);
      check("R10 a20", {7'd0, a20_gate}, 8'd1);
      check("R10 req", {7'd0, cpu_reset_req}, 8'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_a20();
    t_pulse();
    t_busy();
    t_mirror();
    t_same_cycle();
    t_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule